// File: doc/BRIEF.md
# Vector Lane Shift-Left Immediate Unit

This block shifts every lane of a 128-bit vector left by an amount taken from an immediate field. The lane width is picked by a two-bit size code. The immediate carries a size bias, and the unit removes that bias to get the shift amount. Three operations are available. A plain shift moves source bits up within each lane. An insert shift places the shifted source lane over the old destination lane and keeps the destination bits below the shift point. A widening shift takes eight bytes of the source, zero-extends each lane to twice its width, and then shifts it.

A one-cycle start pulse captures the operands. The result is loaded into an output register on that same clock edge. A small two-state controller (states ST_IDLE and ST_OUT) raises a valid strobe while the new result is presented. The controller moves from ST_IDLE to ST_OUT on start. From ST_OUT it stays in ST_OUT when another start arrives, and otherwise returns to ST_IDLE. An illegal request produces an error flag and an all-zero result.

Top module: `shl_imm_unit`

## Requirements
- R1: Size code 0, 1, 2 or 3 selects lanes of 8, 16, 32 or 64 bits, giving 16, 8, 4 or 2 lanes across the 128-bit vector (lane 0 in the least significant bits).
- R2: The shift amount is the immediate minus (8 << size code), keeping only the low log2(lane width) bits of the difference.
- R3: Operation code 0 (plain shift) shifts each lane left. Bits that pass the lane top are dropped, and zeros fill from the bottom.
- R4: Operation code 1 (insert shift) gives each lane as (source lane << shift) OR (destination lane AND a mask of the low `shift` bits).
- R5: In insert shift with a shift amount of zero, the mask is empty, so the result lane equals the source lane.
- R6: For operation codes 0 and 1, when the width flag is 0 (64-bit form), result bits 127:64 are zero.
- R7: Operation code 2 (widening shift) reads source bits 127:64 when the width flag is 1 and source bits 63:0 when the width flag is 0.
- R8: In widening shift, each selected lane is zero-extended to twice its width and then shifted left, and the widened lanes fill all 128 result bits whatever the width flag.
- R9: Operation code 3, or operation code 2 with size code 3, sets the error flag and gives a zero result. Any other request clears the error flag.
- R10: The result, error flag and valid strobe update on the rising edge that samples start high. Valid stays high for one cycle per start. Without start, the result holds.
- R11: After reset, valid, error and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse that captures the operands |
| op_i | input | 2 | Operation code: 0 plain, 1 insert, 2 widen, 3 reserved |
| size_i | input | 2 | Lane size code |
| imm_i | input | 7 | Biased shift immediate |
| wide_i | input | 1 | Width flag: 1 for the 128-bit form, 0 for the 64-bit form |
| src_i | input | 128 | Source vector |
| dst_i | input | 128 | Old destination vector, used by insert shift |
| valid_o | output | 1 | Result strobe |
| err_o | output | 1 | Illegal request flag |
| result_o | output | 128 | Registered result |

## Verification
Every result, error flag and valid strobe is due on the first rising edge after the start pulse is driven. The bench drives each request on a falling edge and then checks the outputs on the next falling edge, which falls half a period after the register loads. One cycle after that, it checks that valid has dropped and that the result register has held its value. A reference model in the bench gives the expected result for each vector in the table. The directed cases compare against values worked out by hand.

// File: rtl/shl_imm_pkg.sv
package shl_imm_pkg;

    typedef enum logic [1:0] {
        OP_SHL   = 2'd0,
        OP_INS   = 2'd1,
        OP_WIDEN = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } state_e;

    localparam int NUM_SIZES = 4;

endpackage

// File: rtl/shl_lane_shift.sv
module shl_lane_shift #(
    parameter int VEC_W = 128,
    parameter int IMM_W = 7
) (
    input  logic [1:0]       size_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             insert_i,
    input  logic [VEC_W-1:0] src_i,
    input  logic [VEC_W-1:0] dst_i,
    output logic [VEC_W-1:0] res_o
);
    import shl_imm_pkg::*;

    logic [VEC_W-1:0] by_size [NUM_SIZES];

    // One shifter array per lane width; the size code picks one below.
    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int EW    = 8 << s;
        localparam int LANES = VEC_W / EW;
        localparam int SHW   = $clog2(EW);

        logic [SHW-1:0] sh;
        logic [EW-1:0]  keep_mask;

        assign sh        = SHW'(imm_i - IMM_W'(EW));
        assign keep_mask = (EW'(1) << sh) - EW'(1);

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [EW-1:0] s_lane;
            logic [EW-1:0] d_lane;
            assign s_lane = src_i[l*EW +: EW];
            assign d_lane = dst_i[l*EW +: EW];
            assign by_size[s][l*EW +: EW] =
                (s_lane << sh) | (insert_i ? (d_lane & keep_mask) : '0);
        end
    end

    assign res_o = by_size[size_i];

endmodule

// File: rtl/shl_widen.sv
module shl_widen #(
    parameter int VEC_W = 128,
    parameter int IMM_W = 7
) (
    input  logic [1:0]       size_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             wide_i,
    input  logic [VEC_W-1:0] src_i,
    output logic [VEC_W-1:0] res_o
);
    import shl_imm_pkg::*;

    localparam int HALF_W = VEC_W / 2;

    logic [HALF_W-1:0] half;
    logic [VEC_W-1:0]  by_size [NUM_SIZES];

    assign half = wide_i ? src_i[VEC_W-1:HALF_W] : src_i[HALF_W-1:0];

    // Size code 3 has no double-width lane; the top flags it as an error.
    assign by_size[NUM_SIZES-1] = '0;

    for (genvar s = 0; s < NUM_SIZES-1; s++) begin : g_size
        localparam int EW    = 8 << s;
        localparam int OW    = 2 * EW;
        localparam int LANES = HALF_W / EW;
        localparam int SHW   = $clog2(EW);

        logic [SHW-1:0] sh;
        assign sh = SHW'(imm_i - IMM_W'(EW));

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [OW-1:0] ext;
            assign ext = {{EW{1'b0}}, half[l*EW +: EW]};
            assign by_size[s][l*OW +: OW] = ext << sh;
        end
    end

    assign res_o = by_size[size_i];

endmodule

// File: rtl/shl_out_ctrl.sv
module shl_out_ctrl #(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [VEC_W-1:0] nxt_result_i,
    input  logic             nxt_err_i,
    output logic             valid_o,
    output logic             err_o,
    output logic [VEC_W-1:0] result_o
);
    import shl_imm_pkg::*;

    state_e           state_q, state_d;
    logic [VEC_W-1:0] result_q;
    logic             err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_OUT;
            ST_OUT:  state_d = start_i ? ST_OUT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            err_q    <= 1'b0;
        end else if (start_i) begin
            result_q <= nxt_result_i;
            err_q    <= nxt_err_i;
        end
    end

    assign valid_o  = (state_q == ST_OUT);
    assign err_o    = err_q;
    assign result_o = result_q;

    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(start_i)); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_q)); // R10
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (result_q == '0)); // R9

endmodule

// File: rtl/shl_imm_unit.sv
module shl_imm_unit #(
    parameter int VEC_W = 128,
    parameter int IMM_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [1:0]       size_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             wide_i,
    input  logic [VEC_W-1:0] src_i,
    input  logic [VEC_W-1:0] dst_i,
    output logic             valid_o,
    output logic             err_o,
    output logic [VEC_W-1:0] result_o
);
    import shl_imm_pkg::*;

    localparam int HALF_W = VEC_W / 2;

    logic [VEC_W-1:0] lane_res;
    logic [VEC_W-1:0] widen_res;
    logic [VEC_W-1:0] nxt_result;
    logic             nxt_err;
    logic             is_insert;

    assign is_insert = (op_i == OP_INS);

    shl_lane_shift #(.VEC_W(VEC_W), .IMM_W(IMM_W)) lane_i (
        .size_i   (size_i),
        .imm_i    (imm_i),
        .insert_i (is_insert),
        .src_i    (src_i),
        .dst_i    (dst_i),
        .res_o    (lane_res)
    );

    shl_widen #(.VEC_W(VEC_W), .IMM_W(IMM_W)) widen_i (
        .size_i (size_i),
        .imm_i  (imm_i),
        .wide_i (wide_i),
        .src_i  (src_i),
        .res_o  (widen_res)
    );

    always_comb begin
        nxt_err    = (op_i == OP_RSVD) || ((op_i == OP_WIDEN) && (size_i == 2'd3));
        nxt_result = '0;
        unique case (op_i)
            OP_SHL, OP_INS: begin
                nxt_result = lane_res;
                if (!wide_i) nxt_result[VEC_W-1:HALF_W] = '0;
            end
            OP_WIDEN: nxt_result = widen_res;
            default:  nxt_result = '0;
        endcase
        if (nxt_err) nxt_result = '0;
    end

    shl_out_ctrl #(.VEC_W(VEC_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .nxt_result_i (nxt_result),
        .nxt_err_i    (nxt_err),
        .valid_o      (valid_o),
        .err_o        (err_o),
        .result_o     (result_o)
    );

    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !wide_i && (op_i == OP_SHL || op_i == OP_INS))
        |=> (result_o[VEC_W-1:HALF_W] == '0)); // R6
    AST_INSERT_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && wide_i && op_i == OP_INS && size_i == 2'd0 && imm_i == IMM_W'(8))
        |=> (result_o == $past(src_i))); // R5
    AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == OP_RSVD) |=> (err_o && valid_o)); // R9

endmodule

// File: tb/shl_imm_unit_tb.sv
`timescale 1ns/1ps
module shl_imm_unit_tb_top;

    typedef struct packed {
        logic [1:0]   op;
        logic [1:0]   sz;
        logic [6:0]   imm;
        logic         wide;
        logic [127:0] src;
        logic [127:0] dst;
    } vec_t;

    localparam int NV = 12;
    localparam logic [127:0] PA = 128'h0123456789abcdeffedcba9876543210;
    localparam logic [127:0] PB = 128'hf0e1d2c3b4a5968778695a4b3c2d1e0f;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 7'd11, 1'b1, PA, PB},   // R1 R3 bytes, shift 3
        '{2'd0, 2'd1, 7'd23, 1'b1, PB, PA},   // R1 R3 halves, shift 7
        '{2'd0, 2'd2, 7'd63, 1'b1, PA, PB},   // R1 R3 words, shift 31
        '{2'd0, 2'd3, 7'd100, 1'b0, PB, PA},  // R1 R6 doubles, 64-bit form
        '{2'd1, 2'd0, 7'd13, 1'b0, PA, PB},   // R4 R6
        '{2'd1, 2'd2, 7'd41, 1'b1, PB, PA},   // R4 words, shift 9
        '{2'd1, 2'd3, 7'd127, 1'b1, PA, PB},  // R4 shift 63
        '{2'd0, 2'd0, 7'd3, 1'b1, PA, PB},    // R2 immediate below bias
        '{2'd2, 2'd0, 7'd10, 1'b1, PA, PB},   // R7 R8 upper half
        '{2'd2, 2'd1, 7'd20, 1'b0, PB, PA},   // R7 R8 lower half
        '{2'd2, 2'd2, 7'd63, 1'b1, PB, PA},   // R8 shift 31
        '{2'd2, 2'd2, 7'd32, 1'b0, PA, PB}    // R8 shift 0
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op = '0;
    logic [1:0]   sz = '0;
    logic [6:0]   imm = '0;
    logic         wide = 1'b0;
    logic [127:0] src = '0;
    logic [127:0] dst = '0;
    logic         valid;
    logic         err;
    logic [127:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    shl_imm_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .size_i(sz),
        .imm_i(imm), .wide_i(wide), .src_i(src), .dst_i(dst),
        .valid_o(valid), .err_o(err), .result_o(result)
    );

    function automatic logic [128:0] model(logic [1:0] o, logic [1:0] s, logic [6:0] im,
                                           logic w, logic [127:0] a, logic [127:0] d);
        int e, sh, pos, ow, base;
        logic [127:0] r;
        logic [63:0]  h;
        r = '0;
        e = 8 << s;
        if (o == 2'd3 || (o == 2'd2 && s == 2'd3)) return {1'b1, 128'b0};
        sh = (int'(im) - e) & (e - 1);
        if (o != 2'd2) begin
            for (int b = 0; b < 128; b++) begin
                pos = b % e;
                if (pos >= sh) r[b] = a[b - sh];
                else if (o == 2'd1) r[b] = d[b];
            end
            if (!w) r[127:64] = '0;
        end else begin
            h  = w ? a[127:64] : a[63:0];
            ow = 2 * e;
            for (int b = 0; b < 128; b++) begin
                pos  = b % ow;
                base = (b / ow) * e;
                if (pos >= sh && pos - sh < e) r[b] = h[base + pos - sh];
            end
        end
        return {1'b0, r};
    endfunction

    task automatic chk(string tag, logic [128:0] act, logic [128:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [1:0] o, logic [1:0] s, logic [6:0] im, logic w,
                         logic [127:0] a, logic [127:0] d);
        @(negedge clk);
        op = o; sz = s; imm = im; wide = w; src = a; dst = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        chk("R11 reset", {err, result}, 129'b0);
        chk("R11 reset valid", {128'b0, valid}, 129'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].sz, VECS[i].imm, VECS[i].wide, VECS[i].src, VECS[i].dst);
            chk("R1 R2 R3 R4 R6 R7 R8 table", {err, result},
                model(VECS[i].op, VECS[i].sz, VECS[i].imm, VECS[i].wide, VECS[i].src, VECS[i].dst));
            chk("R10 valid", {128'b0, valid}, 129'd1);
        end

        issue(2'd0, 2'd0, 7'd9, 1'b1, {16{8'h81}}, '0);
        chk("R3 drop top bit", {err, result}, {1'b0, {16{8'h02}}});
        held = result;
        @(negedge clk);
        chk("R10 strobe one cycle", {128'b0, valid}, 129'd0);
        chk("R10 result holds", {1'b0, result}, {1'b0, held});

        issue(2'd1, 2'd0, 7'd12, 1'b1, {16{8'hab}}, {16{8'hcd}});
        chk("R4 insert bytes", {err, result}, {1'b0, {16{8'hbd}}});

        issue(2'd1, 2'd0, 7'd8, 1'b1, PA, PB);
        chk("R5 zero shift insert", {err, result}, {1'b0, PA});

        issue(2'd0, 2'd1, 7'd16, 1'b0, PB, PA);
        chk("R6 upper cleared", {err, result}, {1'b0, 64'b0, PB[63:0]});

        issue(2'd2, 2'd0, 7'd9, 1'b1, {{8{8'hff}}, 64'b0}, '0);
        chk("R7 upper half widened", {err, result}, {1'b0, {8{16'h01fe}}});

        issue(2'd2, 2'd0, 7'd9, 1'b0, {{8{8'hff}}, 64'b0}, '0);
        chk("R7 lower half widened", {err, result}, 129'b0);

        issue(2'd2, 2'd3, 7'd64, 1'b1, PA, PB);
        chk("R9 widen size 3", {err, result}, {1'b1, 128'b0});

        issue(2'd3, 2'd0, 7'd9, 1'b1, PA, PB);
        chk("R9 reserved op", {err, result}, {1'b1, 128'b0});

        issue(2'd0, 2'd3, 7'd64, 1'b1, PA, PB);
        chk("R9 error clears", {err, result}, {1'b0, PA});

        @(negedge clk);
        op = 2'd0; sz = 2'd0; imm = 7'd8; wide = 1'b1; src = PA; start = 1'b1;
        @(negedge clk);
        src = PB;
        @(negedge clk);
        start = 1'b0;
        chk("R10 back-to-back", {err, result}, {1'b0, PB});
        chk("R10 back-to-back valid", {128'b0, valid}, 129'd1);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule